// File: doc/BRIEF.md
# Debug Signal Output Multiplexer

This peripheral drives a small bank of debug output pins from a wide bundle of internal observation signals. Every pin owns a 4-bit source selector that picks one of its sixteen dedicated probe inputs. The highest selector code does not pick a probe. It hands the pin to a software-owned output bit. Software changes that bit through a pair of write-one-to-set and write-one-to-clear registers, so no read-modify-write is needed. One control bit gates the whole bank. While the bank is off, every pin sits at 0.

Software reaches the block through a plain memory-mapped register port with a write strobe. Read data follows the address combinationally. Identification words and a version byte let software discover the block. A readback register returns the live pin levels. Software can restore the output bits after a power cycle by writing a saved copy back to the set register.

Top module: `dbgmux_port`

## Requirements
- R1: After reset, the control enable, the select word and the software output bits are all 0, and every pin drives 0.
- R2: Bit 0 of the control register at byte offset 0x000 enables the pins. While it is 0, every pin drives 0 whatever the selectors and software bits hold. Reading the register returns the enable in bit 0 and 0 above it.
- R3: The select register at 0x004 is read/write and holds one 4-bit field per pin, with pin n at bits [4n+3:4n]. A code c below 15 drives pin n from probe input bit 16n+c.
- R4: Select code 15 on pin n drives that pin from software output bit n.
- R5: A write to 0x014 sets every software output bit whose data bit is 1 and leaves the bits written as 0 unchanged. Reading 0x014 returns the current software output bits, so writing that value back after a reset restores them.
- R6: A write to 0x018 clears every software output bit whose data bit is 1 and leaves the others unchanged. The register reads as 0.
- R7: Offset 0x01C returns the software output bits, zero-extended. It is read-only, and a write to it changes nothing.
- R8: Offset 0x010 returns the present pin levels, zero-extended. It is read-only, and a write to it changes nothing.
- R9: Offset 0x3F4 returns the version byte, with the major revision in bits [7:4] and the minor revision in bits [3:0]. Offsets 0x3F8 and 0x3FC return the fixed identification and size words (default 0xD8A00001 and 0x00000400). All three are read-only.
- R10: Any other offset reads 0, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| probe_in | input | 128 | Observation signals, sixteen per pin |
| dbg_pins | output | 8 | Debug output pins |

## Verification
A wrong selector field or a lost enable bit shows on the pins in the cycle after the write that caused it. A wrong software output bit shows there too, as long as some pin selects code 15. So the bench compares every pin after every register write against a model built from the writes alone. A corrupted set or clear operation also shows at once in the readback at 0x014 and 0x01C. A stray update from a read-only or unmapped write appears as a changed control, select or output value on the very next read.

// File: rtl/dbgmux_pkg.sv
package dbgmux_pkg;
   localparam int ADDR_W = 12;
   localparam logic [ADDR_W-1:0] OFS_CTRL   = 12'h000;
   localparam logic [ADDR_W-1:0] OFS_SEL    = 12'h004;
   localparam logic [ADDR_W-1:0] OFS_PINVAL = 12'h010;
   localparam logic [ADDR_W-1:0] OFS_SET    = 12'h014;
   localparam logic [ADDR_W-1:0] OFS_CLR    = 12'h018;
   localparam logic [ADDR_W-1:0] OFS_GPO    = 12'h01C;
   localparam logic [ADDR_W-1:0] OFS_VER    = 12'h3F4;
   localparam logic [ADDR_W-1:0] OFS_IPID   = 12'h3F8;
   localparam logic [ADDR_W-1:0] OFS_SIZE   = 12'h3FC;
endpackage

// File: rtl/dbgmux_regs.sv
module dbgmux_regs
   import dbgmux_pkg::*;
#(
   parameter int NUM_PINS = 8,
   parameter int SEL_W    = 4,
   parameter int DATA_W   = 32
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [ADDR_W-1:0]         addr,
   input  logic [DATA_W-1:0]         wdata,
   output logic                      en_q,
   output logic [NUM_PINS*SEL_W-1:0] sel_q,
   output logic [NUM_PINS-1:0]       gpo_q
);
   localparam int SELS_W = NUM_PINS * SEL_W;

   logic wr_ctrl, wr_sel, wr_set, wr_clr, wr_other;
   logic [NUM_PINS-1:0] wbits;

   assign wr_ctrl  = we && (addr == OFS_CTRL);
   assign wr_sel   = we && (addr == OFS_SEL);
   assign wr_set   = we && (addr == OFS_SET);
   assign wr_clr   = we && (addr == OFS_CLR);
   assign wr_other = we && !(wr_ctrl || wr_sel || wr_set || wr_clr);
   assign wbits    = wdata[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q  <= 1'b0;
         sel_q <= '0;
         gpo_q <= '0;
      end else begin
         if (wr_ctrl) en_q  <= wdata[0];
         if (wr_sel)  sel_q <= wdata[SELS_W-1:0];
         if (wr_set)  gpo_q <= gpo_q | wbits;
         else if (wr_clr) gpo_q <= gpo_q & ~wbits;
      end
   end

   assert_sel_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_sel |=> sel_q == $past(wdata[SELS_W-1:0]));
   assert_set_hits_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> (gpo_q & $past(wbits)) == $past(wbits));
   assert_set_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_set |=> (gpo_q & ~$past(wbits)) == ($past(gpo_q) & ~$past(wbits)));
   assert_clr_hits_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (gpo_q & $past(wbits)) == '0);
   assert_clr_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_clr |=> (gpo_q & ~$past(wbits)) == ($past(gpo_q) & ~$past(wbits)));
   assert_inert_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
      wr_other |=> $stable(en_q) && $stable(sel_q) && $stable(gpo_q));
endmodule

// File: rtl/dbgmux_lane.sv
module dbgmux_lane #(
   parameter int SEL_W = 4
) (
   input  logic [(1<<SEL_W)-1:0] probes,
   input  logic [SEL_W-1:0]      code,
   input  logic                  gpo_bit,
   input  logic                  enable,
   output logic                  pin
);
   localparam int SRC = 1 << SEL_W;
   localparam logic [SEL_W-1:0] GPO_CODE = SEL_W'(SRC - 1);

   logic picked;
   always_comb begin
      if (code == GPO_CODE) picked = gpo_bit;
      else                  picked = probes[code];
   end
   assign pin = enable & picked;
endmodule

// File: rtl/dbgmux_rdmux.sv
module dbgmux_rdmux
   import dbgmux_pkg::*;
#(
   parameter int          NUM_PINS  = 8,
   parameter int          SEL_W     = 4,
   parameter int          DATA_W    = 32,
   parameter logic [3:0]  VER_MAJOR = 4'd1,
   parameter logic [3:0]  VER_MINOR = 4'd0,
   parameter logic [31:0] IP_ID     = 32'hD8A0_0001,
   parameter logic [31:0] SIZE_ID   = 32'h0000_0400
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic                      en,
   input  logic [NUM_PINS*SEL_W-1:0] sel,
   input  logic [NUM_PINS-1:0]       gpo,
   input  logic [NUM_PINS-1:0]       pins,
   output logic [DATA_W-1:0]         rdata
);
   localparam int SELS_W = NUM_PINS * SEL_W;

   always_comb begin
      rdata = '0;
      unique case (addr)
         OFS_CTRL:   rdata[0] = en;
         OFS_SEL:    rdata[SELS_W-1:0] = sel;
         OFS_PINVAL: rdata[NUM_PINS-1:0] = pins;
         OFS_SET:    rdata[NUM_PINS-1:0] = gpo;
         OFS_GPO:    rdata[NUM_PINS-1:0] = gpo;
         OFS_VER:    rdata[7:0] = {VER_MAJOR, VER_MINOR};
         OFS_IPID:   rdata = DATA_W'(IP_ID);
         OFS_SIZE:   rdata = DATA_W'(SIZE_ID);
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/dbgmux_port.sv
module dbgmux_port
   import dbgmux_pkg::*;
#(
   parameter int          NUM_PINS  = 8,
   parameter int          SEL_W     = 4,
   parameter int          DATA_W    = 32,
   parameter bit          REG_PINS  = 1'b0,
   parameter logic [3:0]  VER_MAJOR = 4'd1,
   parameter logic [3:0]  VER_MINOR = 4'd0,
   parameter logic [31:0] IP_ID     = 32'hD8A0_0001,
   parameter logic [31:0] SIZE_ID   = 32'h0000_0400
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             bus_we,
   input  logic [ADDR_W-1:0]                bus_addr,
   input  logic [DATA_W-1:0]                bus_wdata,
   output logic [DATA_W-1:0]                bus_rdata,
   input  logic [NUM_PINS*(1<<SEL_W)-1:0]   probe_in,
   output logic [NUM_PINS-1:0]              dbg_pins
);
   localparam int SRC    = 1 << SEL_W;
   localparam int SELS_W = NUM_PINS * SEL_W;

   if (SELS_W > DATA_W) begin : g_bad_sel_width
      $error("select fields do not fit in one data word");
   end
   if (DATA_W < 32) begin : g_bad_data_width
      $error("identification words need a 32-bit data path");
   end

   logic                en_q;
   logic [SELS_W-1:0]   sel_q;
   logic [NUM_PINS-1:0] gpo_q;
   logic [NUM_PINS-1:0] lane_pin;

   dbgmux_regs #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
      .en_q(en_q), .sel_q(sel_q), .gpo_q(gpo_q)
   );

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_lane
      dbgmux_lane #(.SEL_W(SEL_W)) u_lane (
         .probes (probe_in[n*SRC +: SRC]),
         .code   (sel_q[n*SEL_W +: SEL_W]),
         .gpo_bit(gpo_q[n]),
         .enable (en_q),
         .pin    (lane_pin[n])
      );
   end

   if (REG_PINS) begin : g_pin_flop
      logic [NUM_PINS-1:0] pin_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pin_q <= '0;
         else        pin_q <= lane_pin;
      end
      assign dbg_pins = pin_q;
      assert_quiet_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == OFS_CTRL && !bus_wdata[0]) |=> ##1 (dbg_pins == '0));
   end else begin : g_pin_comb
      assign dbg_pins = lane_pin;
      assert_quiet_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (bus_we && bus_addr == OFS_CTRL && !bus_wdata[0]) |=> (dbg_pins == '0));
   end

   dbgmux_rdmux #(
      .NUM_PINS(NUM_PINS), .SEL_W(SEL_W), .DATA_W(DATA_W),
      .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR), .IP_ID(IP_ID), .SIZE_ID(SIZE_ID)
   ) u_rdmux (
      .addr(bus_addr), .en(en_q), .sel(sel_q), .gpo(gpo_q), .pins(dbg_pins),
      .rdata(bus_rdata)
   );

   assert_gpo_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_we && bus_addr == OFS_GPO) |-> bus_rdata == DATA_W'(gpo_q));
endmodule

// File: tb/dbgmux_port_test.sv
module dbgmux_port_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_we = 1'b0;
   logic [11:0]  bus_addr = '0;
   logic [31:0]  bus_wdata = '0;
   logic [31:0]  bus_rdata;
   logic [127:0] probe_in = '0;
   logic [7:0]   dbg_pins;

   int n_vec = 0;
   int n_bad = 0;

   logic        m_en;
   logic [31:0] m_sel;
   logic [7:0]  m_gpo;

   dbgmux_port uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .probe_in(probe_in),
      .dbg_pins(dbg_pins)
   );

   always #10 clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] model_pins();
      logic [7:0] r;
      for (int n = 0; n < 8; n++) begin
         logic [3:0] c;
         c = m_sel[4*n +: 4];
         r[n] = (c == 4'hF) ? m_gpo[n] : probe_in[16*n + c];
      end
      return m_en ? r : 8'h00;
   endfunction

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
      case (a)
         12'h000: m_en = d[0];
         12'h004: m_sel = d;
         12'h014: m_gpo = m_gpo | d[7:0];
         12'h018: m_gpo = m_gpo & ~d[7:0];
         default: ;
      endcase
      #2;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      bus_addr = a;
      #2;
      d = bus_rdata;
   endtask

   task automatic chk_pins(input string req);
      logic [31:0] v;
      #1;
      chk(req, {24'h0, dbg_pins}, {24'h0, model_pins()});
      rd(12'h010, v);
      chk(req, v, {24'h0, model_pins()});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      m_en = 1'b0; m_sel = '0; m_gpo = '0;
      @(negedge clk);
      rst_n = 1'b1;
      #2;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      rd(12'h000, v); chk("R1 ctrl", v, 32'h0);
      rd(12'h004, v); chk("R1 sel", v, 32'h0);
      rd(12'h01C, v); chk("R1 gpo", v, 32'h0);
      chk("R1 pins", {24'h0, dbg_pins}, 32'h0);
   endtask

   task automatic t_enable();
      logic [31:0] v;
      probe_in = {4{32'hA5C3_96F0}};
      wr(12'h014, 32'hFF);
      wr(12'h004, 32'hF0F0_0F01);
      chk_pins("R2 disabled gate");
      chk("R2 all low", {24'h0, dbg_pins}, 32'h0);
      wr(12'h000, 32'hFFFF_FFFF);
      rd(12'h000, v); chk("R2 ctrl read", v, 32'h1);
      chk_pins("R2 enabled");
      wr(12'h000, 32'h0000_0002);
      chk_pins("R2 bit1 only disables");
      chk("R2 low again", {24'h0, dbg_pins}, 32'h0);
      wr(12'h000, 32'h1);
      wr(12'h018, 32'hFF);
   endtask

   task automatic t_route();
      logic [31:0] v;
      logic [127:0] pats [3];
      pats[0] = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F1E_2D3C, 32'h4B5A_6978};
      pats[1] = ~pats[0];
      pats[2] = {64'h8000_0001_0000_8001, 64'h0101_1010_FFFF_0000};
      for (int p = 0; p < 3; p++) begin
         probe_in = pats[p];
         for (int c = 0; c < 15; c++) begin
            wr(12'h004, {8{c[3:0]}});
            chk_pins("R3 uniform code");
         end
      end
      for (int n = 0; n < 8; n++) begin
         probe_in = 128'h0;
         probe_in[16*n + 2*n] = 1'b1;
         wr(12'h004, 32'h0);
         m_sel[4*n +: 4] = 4'(2*n);
         wr(12'h004, m_sel);
         chk("R3 single probe", {24'h0, dbg_pins}, 32'(1 << n));
      end
      probe_in = pats[0];
      wr(12'h004, 32'h7E5C_3A18);
      chk_pins("R3 mixed codes");
      rd(12'h004, v); chk("R3 sel readback", v, 32'h7E5C_3A18);
   endtask

   task automatic t_gpo_route();
      probe_in = '1;
      wr(12'h004, 32'hFFFF_FFFF);
      chk_pins("R4 all gpo low");
      chk("R4 probes masked", {24'h0, dbg_pins}, 32'h0);
      wr(12'h014, 32'h0000_00A5);
      chk_pins("R4 gpo pattern");
      chk("R4 value", {24'h0, dbg_pins}, 32'hA5);
      probe_in = '0;
      wr(12'h004, 32'hF0F0_F0F0);
      chk_pins("R4 alternate lanes");
   endtask

   task automatic t_setclr();
      logic [31:0] v;
      wr(12'h018, 32'hFF);
      wr(12'h014, 32'h0000_0011);
      wr(12'h014, 32'hFFFF_FF42);
      rd(12'h014, v); chk("R5 set accumulates", v, 32'h0000_00FF & 32'h53 | 32'hFFFF_FF00 & 32'h0 | 32'h53);
      wr(12'h014, 32'h0);
      rd(12'h014, v); chk("R5 zero write keeps", v, 32'h53);
      wr(12'h018, 32'h0000_0003);
      rd(12'h01C, v); chk("R6 clear bits", v, 32'h50);
      wr(12'h018, 32'h0);
      rd(12'h01C, v); chk("R6 zero clear keeps", v, 32'h50);
      rd(12'h018, v); chk("R6 clr reads zero", v, 32'h0);
      chk_pins("R6 pins follow");
   endtask

   task automatic t_readonly();
      logic [31:0] v;
      wr(12'h01C, 32'hFFFF_FFFF);
      rd(12'h01C, v); chk("R7 gpo write ignored", v, {24'h0, m_gpo});
      chk_pins("R7 pins unchanged");
      wr(12'h010, 32'h0);
      wr(12'h010, 32'hFFFF_FFFF);
      chk_pins("R8 pinval write ignored");
      rd(12'h004, v); chk("R8 sel unchanged", v, m_sel);
      rd(12'h000, v); chk("R8 ctrl unchanged", v, 32'h1);
   endtask

   task automatic t_ids();
      logic [31:0] v;
      rd(12'h3F4, v); chk("R9 version", v, 32'h0000_0010);
      chk("R9 major", {28'h0, v[7:4]}, 32'h1);
      rd(12'h3F8, v); chk("R9 ip id", v, 32'hD8A0_0001);
      rd(12'h3FC, v); chk("R9 size id", v, 32'h0000_0400);
      wr(12'h3F8, 32'h0);
      rd(12'h3F8, v); chk("R9 ip id kept", v, 32'hD8A0_0001);
   endtask

   task automatic t_undef();
      logic [31:0] v;
      logic [11:0] holes [6];
      holes[0] = 12'h008; holes[1] = 12'h00C; holes[2] = 12'h020;
      holes[3] = 12'h100; holes[4] = 12'h3F0; holes[5] = 12'hFFC;
      for (int i = 0; i < 6; i++) begin
         wr(holes[i], 32'hFFFF_FFFF);
         rd(holes[i], v); chk("R10 hole reads zero", v, 32'h0);
      end
      wr(12'h000, 32'h0);
      wr(12'h008, 32'h0000_0001);
      rd(12'h000, v); chk("R10 ctrl untouched", v, 32'h0);
      rd(12'h004, v); chk("R10 sel untouched", v, m_sel);
      rd(12'h01C, v); chk("R10 gpo untouched", v, {24'h0, m_gpo});
      chk_pins("R10 pins untouched");
   endtask

   task automatic t_restore();
      logic [31:0] saved, v;
      wr(12'h000, 32'h1);
      wr(12'h004, 32'hFFFF_FFFF);
      wr(12'h018, 32'hFF);
      wr(12'h014, 32'h3C);
      rd(12'h014, saved);
      do_reset();
      rd(12'h01C, v); chk("R1 gpo after reset", v, 32'h0);
      wr(12'h000, 32'h1);
      wr(12'h004, 32'hFFFF_FFFF);
      wr(12'h014, saved);
      rd(12'h01C, v); chk("R5 restore", v, 32'h3C);
      chk_pins("R5 restored pins");
   endtask

   initial begin
      m_en = 1'b0; m_sel = '0; m_gpo = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable();
      t_route();
      t_gpo_route();
      t_setclr();
      t_readonly();
      t_ids();
      t_undef();
      t_restore();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not end, actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule